// File: doc/BRIEF.md
# Colour Threshold Alpha Stage

This stage sits behind a colour-space converter and post-processes its RGB32 output one pixel per clock. Two 9-bit thresholds, loaded together by a single threshold command word, drive a two-level key. Dark pixels, meaning those whose three colour components are all under the lower threshold, are erased to an all-zero word. Pixels that are only moderately dark, with all three components under the upper threshold, keep their colours but have their alpha byte replaced by a fixed "semi-transparent" code. A per-pixel sign option then flips the most significant bit of each colour byte, which turns unsigned output into signed output.

A pixel word is 32 bits wide. R occupies bits 7:0, G bits 15:8, B bits 23:16 and alpha bits 31:24. Pixels enter and leave through valid/ready handshakes, and one output register lies between the two sides. A 16×16 macroblock is 256 pixel beats, and the stage puts no boundaries of its own between macroblocks. A threshold command completes in one cycle and answers with a one-cycle done pulse, which is meant for the interrupt line.

Top module: `thr_alpha_key`

## Requirements
- R1: After reset both thresholds are zero, `px_out_valid` and `cmd_done` are low, `px_in_ready` is high, and pixels pass through unchanged.
- R2: A command sets the lower threshold from `cmd_word[8:0]` and the upper threshold from `cmd_word[24:16]`, and all other bits are ignored. The new thresholds apply to pixels accepted from the cycle after the write onwards. A pixel accepted in the write cycle itself uses the old values. `cmd_done` is high exactly in the cycle after each write.
- R3: When the lower threshold is nonzero and R, G and B are each strictly less than it, the keyed pixel is 0x00000000, with alpha included.
- R4: When the R3 rule does not apply and R, G and B are each strictly less than the upper threshold, alpha becomes 0x40 and R, G and B are kept.
- R5: With a zero lower threshold and a nonzero upper threshold, only the R4 rule can act, and no pixel is zeroed.
- R6: With both thresholds zero, every pixel leaves unchanged apart from the R8 flip.
- R7: Comparisons are strict and 9 bits wide. A component equal to a threshold does not count as below it, and a threshold of 256 or more counts every component value as below it.
- R8: When `px_in_signed` is high for a pixel, bits 7, 15 and 23 of its keyed result are inverted, which is an XOR with 0x00808080 applied after keying. A zeroed pixel therefore leaves as 0x00808080.
- R9: The output appears one cycle after acceptance, in order, with no loss or duplication. `px_in_ready` equals `!px_out_valid || px_out_ready`, and a stalled output holds its valid and data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Threshold command strobe |
| cmd_word | input | 32 | Threshold command word |
| cmd_done | output | 1 | One-cycle completion pulse for a command |
| px_in_valid | input | 1 | Input pixel valid |
| px_in_ready | output | 1 | Stage can accept a pixel |
| px_in_data | input | 32 | Input RGB32 pixel |
| px_in_signed | input | 1 | Apply the signed-output flip to this pixel |
| px_out_valid | output | 1 | Output pixel valid |
| px_out_ready | input | 1 | Downstream accepts the output pixel |
| px_out_data | output | 32 | Keyed pixel |

## Verification
The sweep covers every pairing of seven thresholds, including 0, 1, 255, 256 and 511, with both sign settings. Component values are drawn from each threshold, the values either side of it, and the extremes. This exposes a non-strict compare, which would key components that equal a threshold, and an 8-bit compare, which would miss the 256-and-above case. Threshold commands carry junk in the ignored bits and arrive while pixels are streaming. A stage that latched thresholds a cycle early or late, or decoded the wrong bit field, would mis-key the pixels around the write. Random backpressure catches an output that changes while stalled, as well as dropped or doubled pixels. Zeroed pixels sent with the sign option check that the flip comes after keying: a stage that applied it first would leave 0x00000000 where 0x00808080 is due.

// File: rtl/thr_key_pkg.sv
`timescale 1ns/1ps
package thr_key_pkg;

    typedef enum logic [1:0] {
        KEY_PASS  = 2'd0,
        KEY_ALPHA = 2'd1,
        KEY_ZERO  = 2'd2
    } key_kind_e;

endpackage

// File: rtl/thr_key_regs.sv
`timescale 1ns/1ps
module thr_key_regs #(
    parameter int CMD_W  = 32,
    parameter int THR_W  = 9,
    parameter int LO_LSB = 0,
    parameter int HI_LSB = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_word,
    output logic [THR_W-1:0] thr_lo,
    output logic [THR_W-1:0] thr_hi,
    output logic             cmd_done
);
    localparam logic [CMD_W-1:0] FIELD_ONES = {{(CMD_W-THR_W){1'b0}}, {THR_W{1'b1}}};
    localparam logic [CMD_W-1:0] USED_MASK  = (FIELD_ONES << LO_LSB) | (FIELD_ONES << HI_LSB);

    typedef struct packed {
        logic [THR_W-1:0] lo;
        logic [THR_W-1:0] hi;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;

    logic [CMD_W-1:0] unused_cmd_bits;
    assign unused_cmd_bits = cmd_word & ~USED_MASK;

    always_comb begin
        r_d      = r_q;
        r_d.done = cmd_we;
        if (cmd_we) begin
            r_d.lo = cmd_word[LO_LSB +: THR_W];
            r_d.hi = cmd_word[HI_LSB +: THR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign thr_lo   = r_q.lo;
    assign thr_hi   = r_q.hi;
    assign cmd_done = r_q.done;

    assert_done_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> cmd_done);

    assert_done_only_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $past(cmd_we));

    assert_thr_stable_without_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(thr_lo) && $stable(thr_hi));

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (thr_lo == '0) && (thr_hi == '0) && !cmd_done);

endmodule

// File: rtl/thr_key_classify.sv
`timescale 1ns/1ps
module thr_key_classify
    import thr_key_pkg::*;
#(
    parameter int COMP_W = 8,
    parameter int NCOLOR = 3,
    parameter int THR_W  = 9
) (
    input  logic [(NCOLOR+1)*COMP_W-1:0] pix,
    input  logic [THR_W-1:0]             thr_lo,
    input  logic [THR_W-1:0]             thr_hi,
    output key_kind_e                    kind
);
    logic [NCOLOR-1:0] under_lo;
    logic [NCOLOR-1:0] under_hi;

    for (genvar c = 0; c < NCOLOR; c++) begin : g_cmp
        logic [THR_W-1:0] comp_wide;
        assign comp_wide   = THR_W'(pix[c*COMP_W +: COMP_W]);
        assign under_lo[c] = comp_wide < thr_lo;
        assign under_hi[c] = comp_wide < thr_hi;
    end

    logic [COMP_W-1:0] unused_alpha;
    assign unused_alpha = pix[NCOLOR*COMP_W +: COMP_W];

    always_comb begin
        kind = KEY_PASS;
        if ((|thr_lo) && (&under_lo)) begin
            kind = KEY_ZERO;
        end else if (&under_hi) begin
            kind = KEY_ALPHA;
        end
    end

endmodule

// File: rtl/thr_key_apply.sv
`timescale 1ns/1ps
module thr_key_apply
    import thr_key_pkg::*;
#(
    parameter int               COMP_W    = 8,
    parameter int               NCOLOR    = 3,
    parameter logic [COMP_W-1:0] ALPHA_KEY = 8'h40
) (
    input  logic [(NCOLOR+1)*COMP_W-1:0] pix,
    input  key_kind_e                    kind,
    input  logic                         flip,
    output logic [(NCOLOR+1)*COMP_W-1:0] res
);
    localparam int PIX_W = (NCOLOR + 1) * COMP_W;

    logic [PIX_W-1:0] keyed;
    logic [PIX_W-1:0] flip_mask;

    always_comb begin
        unique case (kind)
            KEY_ZERO:  keyed = '0;
            KEY_ALPHA: keyed = {ALPHA_KEY, pix[NCOLOR*COMP_W-1:0]};
            default:   keyed = pix;
        endcase
    end

    for (genvar c = 0; c <= NCOLOR; c++) begin : g_mask
        if (c < NCOLOR) begin : g_col
            assign flip_mask[c*COMP_W +: COMP_W] = {flip, {(COMP_W-1){1'b0}}};
        end else begin : g_alpha
            assign flip_mask[c*COMP_W +: COMP_W] = '0;
        end
    end

    assign res = keyed ^ flip_mask;

endmodule

// File: rtl/thr_key_stage.sv
`timescale 1ns/1ps
module thr_key_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } stage_t;

    stage_t s_d, s_q;

    assign in_ready = !s_q.valid || out_ready;

    always_comb begin
        s_d = s_q;
        if (in_ready) begin
            s_d.valid = in_valid;
            if (in_valid) begin
                s_d.data = in_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.valid;
    assign out_data  = s_q.data;

    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_accept_shows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_idle_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid && out_ready |=> !out_valid);

endmodule

// File: rtl/thr_alpha_key.sv
`timescale 1ns/1ps
module thr_alpha_key
    import thr_key_pkg::*;
#(
    parameter int                COMP_W    = 8,
    parameter int                NCOLOR    = 3,
    parameter int                THR_W     = 9,
    parameter int                CMD_W     = 32,
    parameter int                LO_LSB    = 0,
    parameter int                HI_LSB    = 16,
    parameter logic [COMP_W-1:0] ALPHA_KEY = 8'h40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_we,
    input  logic [CMD_W-1:0]              cmd_word,
    output logic                          cmd_done,
    input  logic                          px_in_valid,
    output logic                          px_in_ready,
    input  logic [(NCOLOR+1)*COMP_W-1:0]  px_in_data,
    input  logic                          px_in_signed,
    output logic                          px_out_valid,
    input  logic                          px_out_ready,
    output logic [(NCOLOR+1)*COMP_W-1:0]  px_out_data
);
    localparam int PIX_W = (NCOLOR + 1) * COMP_W;

    logic [THR_W-1:0] thr_lo;
    logic [THR_W-1:0] thr_hi;
    key_kind_e        kind;
    logic [PIX_W-1:0] keyed_pix;

    thr_key_regs #(
        .CMD_W  (CMD_W),
        .THR_W  (THR_W),
        .LO_LSB (LO_LSB),
        .HI_LSB (HI_LSB)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_word (cmd_word),
        .thr_lo   (thr_lo),
        .thr_hi   (thr_hi),
        .cmd_done (cmd_done)
    );

    thr_key_classify #(
        .COMP_W (COMP_W),
        .NCOLOR (NCOLOR),
        .THR_W  (THR_W)
    ) u_classify (
        .pix    (px_in_data),
        .thr_lo (thr_lo),
        .thr_hi (thr_hi),
        .kind   (kind)
    );

    thr_key_apply #(
        .COMP_W    (COMP_W),
        .NCOLOR    (NCOLOR),
        .ALPHA_KEY (ALPHA_KEY)
    ) u_apply (
        .pix  (px_in_data),
        .kind (kind),
        .flip (px_in_signed),
        .res  (keyed_pix)
    );

    thr_key_stage #(
        .W (PIX_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (px_in_valid),
        .in_ready  (px_in_ready),
        .in_data   (keyed_pix),
        .out_valid (px_out_valid),
        .out_ready (px_out_ready),
        .out_data  (px_out_data)
    );

    function automatic logic all_under(input logic [PIX_W-1:0] p, input logic [THR_W-1:0] t);
        logic r;
        r = 1'b1;
        for (int c = 0; c < NCOLOR; c++) begin
            if (!(THR_W'(p[c*COMP_W +: COMP_W]) < t)) r = 1'b0;
        end
        return r;
    endfunction

    assert_zero_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        px_in_valid && px_in_ready && !px_in_signed && (thr_lo != '0) && all_under(px_in_data, thr_lo)
        |=> px_out_data == '0);

    assert_alpha_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        px_in_valid && px_in_ready
        |=> (px_out_data[PIX_W-1 -: COMP_W] == $past(px_in_data[PIX_W-1 -: COMP_W]))
         || (px_out_data[PIX_W-1 -: COMP_W] == ALPHA_KEY)
         || (px_out_data[PIX_W-1 -: COMP_W] == '0));

    assert_no_zero_without_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        px_in_valid && px_in_ready && (thr_lo == '0)
        |=> px_out_data[PIX_W-1 -: COMP_W] != '0 || $past(px_in_data[PIX_W-1 -: COMP_W]) == '0
            || ALPHA_KEY == '0);

    assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
        px_in_valid && px_in_ready && !px_in_signed && (thr_lo == '0) && (thr_hi == '0)
        |=> px_out_data == $past(px_in_data));

endmodule

// File: tb/test_thr_alpha_key.sv
`timescale 1ns/1ps
module test_thr_alpha_key;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_done;
    logic        px_in_valid = 1'b0;
    logic        px_in_ready;
    logic [31:0] px_in_data = '0;
    logic        px_in_signed = 1'b0;
    logic        px_out_valid;
    logic        px_out_ready = 1'b0;
    logic [31:0] px_out_data;

    always #4 clk = ~clk;

    thr_alpha_key i_thr_alpha_key (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (cmd_we),
        .cmd_word     (cmd_word),
        .cmd_done     (cmd_done),
        .px_in_valid  (px_in_valid),
        .px_in_ready  (px_in_ready),
        .px_in_data   (px_in_data),
        .px_in_signed (px_in_signed),
        .px_out_valid (px_out_valid),
        .px_out_ready (px_out_ready),
        .px_out_data  (px_out_data)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [8:0]  m_lo = '0;
    logic [8:0]  m_hi = '0;
    logic        prev_we = 1'b0;
    logic        hold_pending = 1'b0;
    logic [31:0] hold_data = '0;

    localparam int NT = 7;
    localparam int CYC = 40;
    logic [8:0] tlist [NT] = '{9'd0, 9'd1, 9'h040, 9'h080, 9'h0FF, 9'h100, 9'h1FF};

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] p, input logic [8:0] lo,
                                          input logic [8:0] hi, input logic sg, output string tag);
        logic [31:0] res;
        logic blo, bhi;
        blo = (lo != 0) && ({1'b0, p[7:0]} < lo) && ({1'b0, p[15:8]} < lo) && ({1'b0, p[23:16]} < lo);
        bhi = ({1'b0, p[7:0]} < hi) && ({1'b0, p[15:8]} < hi) && ({1'b0, p[23:16]} < hi);
        if (blo) begin
            res = 32'h0; tag = "R3";
        end else if (bhi) begin
            res = {8'h40, p[23:0]}; tag = (lo == 0) ? "R5" : "R4";
        end else begin
            res = p; tag = (lo == 0 && hi == 0) ? "R6" : "R7";
        end
        if (sg) begin
            res = res ^ 32'h0080_8080; tag = "R8";
        end
        return res;
    endfunction

    function automatic logic [7:0] pick(input logic [8:0] t0, input logic [8:0] t1);
        int v;
        case ($urandom % 8)
            0: v = 0;
            1: v = 255;
            2: v = int'(t0) - 1;
            3: v = int'(t0);
            4: v = int'(t1) - 1;
            5: v = int'(t1);
            6: v = int'($urandom % 256);
            default: v = int'(t0) + 1;
        endcase
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return 8'(v);
    endfunction

    task automatic step();
        string t;
        logic [31:0] e;
        check(cmd_done === prev_we, "R2", {31'd0, cmd_done}, {31'd0, prev_we});
        if (hold_pending) begin
            check(px_out_valid === 1'b1 && px_out_data === hold_data, "R9", px_out_data, hold_data);
        end
        hold_pending = px_out_valid && !px_out_ready;
        hold_data = px_out_data;
        if (px_out_valid && px_out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", px_out_data, 32'hxxxx_xxxx);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(px_out_data === e, t, px_out_data, e);
            end
        end
        if (px_in_valid && px_in_ready) begin
            e = model(px_in_data, m_lo, m_hi, px_in_signed, t);
            if (cmd_we && (cmd_word[8:0] != m_lo || cmd_word[24:16] != m_hi)) t = "R2";
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
        if (cmd_we) begin
            m_lo = cmd_word[8:0];
            m_hi = cmd_word[24:16];
        end
        prev_we = cmd_we;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state at the ports
        check(px_out_valid === 1'b0, "R1", {31'd0, px_out_valid}, 32'd0);
        check(cmd_done === 1'b0, "R1", {31'd0, cmd_done}, 32'd0);
        check(px_in_ready === 1'b1, "R1", {31'd0, px_in_ready}, 32'd1);

        // R1: with reset thresholds a dark pixel passes unchanged
        @(negedge clk);
        px_in_valid = 1'b1; px_in_data = 32'h7F01_0000; px_out_ready = 1'b1;
        #1; step();
        @(negedge clk);
        px_in_valid = 1'b0;
        #1;
        check(px_out_data === 32'h7F01_0000, "R1", px_out_data, 32'h7F01_0000);
        step();

        for (int a = 0; a < NT; a++) begin
            for (int b = 0; b < NT; b++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int c = 0; c < CYC; c++) begin
                        @(negedge clk);
                        cmd_we = (c == 2);
                        cmd_word = {7'($urandom), tlist[b], 7'($urandom), tlist[a]};
                        px_in_valid = ($urandom % 5) != 0;
                        px_in_data = {8'($urandom), pick(tlist[a], tlist[b]),
                                      pick(tlist[a], tlist[b]), pick(tlist[a], tlist[b])};
                        px_in_signed = s[0];
                        px_out_ready = ($urandom % 4) != 0;
                        #1; step();
                    end
                end
            end
        end

        for (int d = 0; d < 10; d++) begin
            @(negedge clk);
            cmd_we = 1'b0;
            px_in_valid = 1'b0;
            px_out_ready = 1'b1;
            #1; step();
        end
        // R9: everything accepted has come out
        check(exp_q.size() == 0, "R9", 32'(exp_q.size()), 32'd0);
        check(px_out_valid === 1'b0, "R9", {31'd0, px_out_valid}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule